// File: doc/BRIEF.md
# Bus Cycle Address and ID Decoder

This block decides whether a flash device answers a memory-bus cycle when several such devices share one bus. On the strobe that opens each cycle it reads the latched 24-bit cycle address and checks three things. The device identity code carried in the address must match this device's 4-bit hardware strap. The offset must fall inside the window of the addressed space. One address bit chooses between the flash array and the register space. A device that is addressed answers with a select output for the rest of the cycle. Any other device goes quiet and stays in standby until the next cycle opens.

The identity code is spread over a non-contiguous group of address bits, and it is carried inverted: a strap of 0000 is matched by ones on all four identity bits. The first device on a bus, the boot device, is strapped 0000. Further devices count up from there (0001, 0010, ...). The strap pins are sampled while reset is held and are frozen from the first cycle after reset.

Top module: `bus_id_decoder`

## Requirements
- R1: While and directly after a synchronous reset, `sel`, `to_flash` and `standby` are all 0.
- R2: The strap value present on the last clock edge with `rst` high is the one used; later changes on `id_strap` have no effect until the next reset.
- R3: Identity match means `cyc_addr[23]` equals the inverse of strap bit 3 and `cyc_addr[21:19]` equals the inverse of strap bits 2:0; a boot strap of 0000 is matched by ones on all four bits.
- R4: `cyc_addr[22]` = 1 addresses flash and 0 addresses register space; for a selected cycle, `to_flash` shows that bit from the clock edge that samples `cyc_start` onward, and it is 0 whenever `sel` is 0.
- R5: When `cyc_start` is sampled high with a matching identity and an in-range offset, `sel` is 1 after that clock edge and stays 1 until the next sampled strobe or reset.
- R6: When `cyc_start` is sampled high with an identity mismatch, `standby` is 1 and `sel` is 0 after that edge, and both hold until the next sampled strobe or reset.
- R7: The offset `cyc_addr[18:0]` is in range when it is below FLASH_BYTES for flash space, or below REG_BYTES for register space; an out-of-range cycle gets no response (`sel` 0, `standby` 1).
- R8: A new strobe re-evaluates the cycle from any state, so a matching cycle leaves standby at once.
- R9: Changes on `cyc_addr` while `cyc_start` is low have no effect on any output.
- R10: `sel` and `standby` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; the strap is sampled during it |
| id_strap | input | 4 | Hardware identity strap |
| cyc_start | input | 1 | One-cycle strobe opening a bus cycle; address valid with it |
| cyc_addr | input | 24 | Latched cycle address |
| sel | output | 1 | Device addressed for the current cycle |
| to_flash | output | 1 | Selected cycle targets flash (1) or registers (0) |
| standby | output | 1 | Cycle ignored; device idle until the next strobe |

## Verification
The bench builds the decoder with FLASH_BYTES = 0x60000 and REG_BYTES = 0x1000, both smaller than the 19-bit offset field. The flash and register range limits can then be hit exactly at their last valid offset and at one past it. With the default full-window sizes no flash offset can be out of range, so these values are what bring the flash side of R7 within reach. A non-zero, non-symmetric strap (0010) shows when the inversion or the bit placement of each identity bit is wrong, and a second reset with strap 0000 covers the boot device.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

    localparam int ADDR_W    = 24;
    localparam int ID_W      = 4;
    localparam int SPACE_BIT = 22;
    localparam int OFF_W     = 19;

    // address bit carrying identity bit i (LSB first)
    localparam int ID_POS [ID_W] = '{19, 20, 21, 23};

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [ID_W-1:0]   id_t;
    typedef logic [OFF_W-1:0]  off_t;

    typedef struct packed {
        logic id_ok;
        logic in_range;
        logic to_flash;
    } decode_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SELECT  = 2'd1,
        ST_STANDBY = 2'd2
    } cyc_state_t;

    function automatic off_t addr_offset(addr_t a);
        return a[OFF_W-1:0];
    endfunction

    function automatic logic addr_is_flash(addr_t a);
        return a[SPACE_BIT];
    endfunction

endpackage

// File: rtl/busdec_strap_latch.sv
module busdec_strap_latch
    import busdec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  id_t  strap_in,
    output id_t  strap_q
);

    // sampled on every reset edge; the last one wins
    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_in;
    end

    a_r2_strap_frozen: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(strap_q));

endmodule

// File: rtl/busdec_field_check.sv
module busdec_field_check
    import busdec_pkg::*;
#(
    parameter int unsigned FLASH_BYTES = 32'd524288,
    parameter int unsigned REG_BYTES   = 32'd65536
) (
    input  addr_t   addr,
    input  id_t     strap,
    output decode_t dec
);

    localparam int unsigned CMP_W = 32;

    logic [ID_W-1:0] bit_eq;

    generate
        for (genvar i = 0; i < ID_W; i++) begin : g_id_bit
            // the address carries the inverted strap
            assign bit_eq[i] = (addr[ID_POS[i]] == ~strap[i]);
        end
    endgenerate

    logic [CMP_W-1:0] off_ext;
    logic             flash_sp;
    logic             flash_ok;
    logic             reg_ok;

    always_comb begin
        off_ext  = CMP_W'(addr_offset(addr));
        flash_sp = addr_is_flash(addr);
        flash_ok = off_ext < FLASH_BYTES;
        reg_ok   = off_ext < REG_BYTES;

        dec.id_ok    = &bit_eq;
        dec.in_range = flash_sp ? flash_ok : reg_ok;
        dec.to_flash = flash_sp;
    end

endmodule

// File: rtl/busdec_cycle_fsm.sv
module busdec_cycle_fsm
    import busdec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  decode_t dec,
    output logic    sel,
    output logic    to_flash,
    output logic    standby
);

    cyc_state_t state_q, state_d;
    logic       flash_q, flash_d;
    logic       hit;

    always_comb begin
        hit     = dec.id_ok && dec.in_range;
        state_d = state_q;
        flash_d = flash_q;
        if (start) begin
            state_d = hit ? ST_SELECT : ST_STANDBY;
            flash_d = hit && dec.to_flash;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            flash_q <= 1'b0;
        end else begin
            state_q <= state_d;
            flash_q <= flash_d;
        end
    end

    assign sel      = (state_q == ST_SELECT);
    assign standby  = (state_q == ST_STANDBY);
    assign to_flash = flash_q;

    a_r9_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(sel) && $stable(standby) && $stable(to_flash)));

    a_r10_sel_standby_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(sel && standby));

    a_r4_flash_needs_sel: assert property (@(posedge clk) disable iff (rst)
        to_flash |-> sel);

endmodule

// File: rtl/bus_id_decoder.sv
module bus_id_decoder
    import busdec_pkg::*;
#(
    parameter int unsigned FLASH_BYTES = 32'd524288,
    parameter int unsigned REG_BYTES   = 32'd65536
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  id_strap,
    input  logic        cyc_start,
    input  logic [23:0] cyc_addr,
    output logic        sel,
    output logic        to_flash,
    output logic        standby
);

    id_t     strap_q;
    decode_t dec;

    busdec_strap_latch u_strap (
        .clk      (clk),
        .rst      (rst),
        .strap_in (id_strap),
        .strap_q  (strap_q)
    );

    busdec_field_check #(
        .FLASH_BYTES (FLASH_BYTES),
        .REG_BYTES   (REG_BYTES)
    ) u_check (
        .addr  (cyc_addr),
        .strap (strap_q),
        .dec   (dec)
    );

    busdec_cycle_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (cyc_start),
        .dec      (dec),
        .sel      (sel),
        .to_flash (to_flash),
        .standby  (standby)
    );

    a_r6_mismatch_standby: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && !dec.id_ok) |=> (standby && !sel));

    a_r5_hit_selects: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && dec.id_ok && dec.in_range) |=> sel);

    a_r7_range_miss: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && !dec.in_range) |=> (!sel && standby));

    a_r4_space_follows_bit: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && dec.id_ok && dec.in_range) |=> (to_flash == $past(cyc_addr[SPACE_BIT])));

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!sel && !standby && !to_flash));

endmodule

// File: tb/sim_bus_id_decoder.sv
module sim_bus_id_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  id_strap;
    logic        cyc_start;
    logic [23:0] cyc_addr;
    logic        sel, to_flash, standby;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk; // 50 MHz

    bus_id_decoder #(
        .FLASH_BYTES (32'h60000),
        .REG_BYTES   (32'h1000)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .id_strap  (id_strap),
        .cyc_start (cyc_start),
        .cyc_addr  (cyc_addr),
        .sel       (sel),
        .to_flash  (to_flash),
        .standby   (standby)
    );

    // entry: {addr_id[3:0], space, offset[23:0], exp_sel, exp_flash, exp_standby}
    // strap 0010 -> matching address identity 1101
    localparam int NV = 10;
    localparam logic [31:0] VEC [NV] = '{
        {4'hD, 1'b1, 24'h000000, 3'b110},  // R4 R5 flash hit
        {4'hD, 1'b0, 24'h000000, 3'b100},  // R4 R5 register hit
        {4'hD, 1'b1, 24'h05FFFF, 3'b110},  // R7 last flash offset
        {4'hD, 1'b1, 24'h060000, 3'b001},  // R7 flash out of range
        {4'hD, 1'b0, 24'h000FFF, 3'b100},  // R7 last register offset
        {4'hD, 1'b0, 24'h001000, 3'b001},  // R7 register out of range
        {4'hC, 1'b1, 24'h000000, 3'b001},  // R3 A19 wrong
        {4'h5, 1'b1, 24'h000000, 3'b001},  // R3 A23 wrong
        {4'h2, 1'b1, 24'h000000, 3'b001},  // R3 strap not inverted
        {4'h9, 1'b1, 24'h000000, 3'b001}   // R3 A21 wrong
    };

    function automatic logic [23:0] mk_addr(logic [3:0] idf, logic sp, logic [18:0] off);
        return {idf[3], sp, idf[2:0], off};
    endfunction

    task automatic expect3(string req, logic es, logic ef, logic eb);
        checks++;
        if (sel !== es || to_flash !== ef || standby !== eb) begin
            errors++;
            $display("FAIL %s: sel/to_flash/standby got %b%b%b expected %b%b%b",
                     req, sel, to_flash, standby, es, ef, eb);
        end
    endtask

    task automatic strobe(logic [23:0] a);
        @(negedge clk);
        cyc_start = 1'b1;
        cyc_addr  = a;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    task automatic do_reset(logic [3:0] s);
        @(negedge clk);
        rst      = 1'b1;
        id_strap = s;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; id_strap = 4'b0010; cyc_start = 1'b0; cyc_addr = '0;
        repeat (3) @(negedge clk);
        expect3("R1 during reset", 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        expect3("R1 after reset", 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            strobe(mk_addr(VEC[i][31:28], VEC[i][27], VEC[i][21:3]));
            expect3("R3/R4/R5/R6/R7 vector", VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R5 R9: hit held while address wanders without strobe
        strobe(mk_addr(4'hD, 1'b1, 19'h00010));
        cyc_addr = mk_addr(4'h0, 1'b0, 19'h7FFFF);
        repeat (3) @(negedge clk);
        expect3("R5 R9 hold selected", 1'b1, 1'b1, 1'b0);

        // R6 R9: standby held
        strobe(mk_addr(4'h3, 1'b1, 19'h0));
        cyc_addr = mk_addr(4'hD, 1'b1, 19'h0);
        repeat (3) @(negedge clk);
        expect3("R6 R9 standby held", 1'b0, 1'b0, 1'b1);

        // R8: next strobe leaves standby
        strobe(mk_addr(4'hD, 1'b0, 19'h00020));
        expect3("R8 leave standby", 1'b1, 1'b0, 1'b0);

        // R2: strap change after reset has no effect
        id_strap = 4'b0000;
        repeat (2) @(negedge clk);
        strobe(mk_addr(4'hD, 1'b1, 19'h0));
        expect3("R2 strap frozen (old id)", 1'b1, 1'b1, 1'b0);
        strobe(mk_addr(4'hF, 1'b1, 19'h0));
        expect3("R2 strap frozen (new id)", 1'b0, 1'b0, 1'b1);

        // R6 R1: reset clears standby; R3 boot strap 0000
        do_reset(4'b0000);
        expect3("R1 reset clears standby", 1'b0, 1'b0, 1'b0);
        strobe(mk_addr(4'hF, 1'b1, 19'h0));
        expect3("R3 boot device all ones", 1'b1, 1'b1, 1'b0);
        strobe(mk_addr(4'hE, 1'b0, 19'h0));
        expect3("R3 boot device bit0 low", 1'b0, 1'b0, 1'b1);

        // R2: second device strap 0001 takes effect via reset
        do_reset(4'b0001);
        strobe(mk_addr(4'hE, 1'b0, 19'h00004));
        expect3("R2 new strap after reset", 1'b1, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule